// File: doc/BRIEF.md
# Three-Wire Serial Register-Access Slave

This block lets an external host read and write a bank of configuration registers over three wires: an active-low select, a serial clock and one bidirectional data line. The data line is split at the block edge into an input, an output and an output-enable, so a tri-state pad outside the block can close the loop. Each transaction opens with a 16-bit instruction word and continues with one or more data bytes. The instruction word holds a direction flag, a two-bit byte count and a 13-bit starting register address. Every payload byte goes to, or comes from, the next register in sequence.

The three serial pins are sampled by the block's own clock through a synchronizer, and edges are found after that synchronizer. Each high phase and each low phase of the serial clock must therefore last at least SYNC_STAGES + 3 cycles of `clk`.

On the register side the block offers a single address bus. It gives a one-cycle write valid pulse together with the write data. Read data is taken from `reg_rd_data` one cycle after the address changes, so the bank must decode the address combinationally within one cycle. A serial host cannot be stalled, so the write valid carries no ready signal and the bank must accept every pulse. The block applies no back-pressure on the serial side either.

Top module: `spi3w_regslave`

## Requirements
- R1: While select is high (after the synchronizer), the block issues no write pulse and keeps the output-enable low. The first rising serial-clock edge after select goes low is always bit 0 of the instruction word, and the output-enable stays low through all 16 instruction bits.
- R2: The instruction word is sent MSB first and is sampled on rising serial-clock edges. Bit 15 is the direction (1 = read, 0 = write), bits 14:13 are the byte count code, and bits 12:0 are the start address.
- R3: Count codes 00, 01 and 10 allow 1, 2 and 3 data bytes. Bytes beyond the allowed count cause no write pulse, and on a read they leave the output-enable low.
- R4: Count code 11 streams bytes for as long as select stays low.
- R5: A write data byte arrives MSB first. A single one-cycle `reg_wr_valid` pulse is issued only after all 8 bits have arrived, with the byte on `reg_wr_data` and the target register on `reg_addr`.
- R6: On a read, the output-enable rises after the first falling serial-clock edge that follows the last instruction bit. The register data is driven MSB first, and `spi_sdio_out` changes only after a falling serial-clock edge.
- R7: After each completed data byte, the address steps by one, modulo 2^13. Byte k of a transaction therefore reaches register (start + k) mod 8192.
- R8: If select rises part way through a byte, or in the same clock in which the eighth rising edge of a byte is seen, that byte is dropped with no write pulse. The output-enable falls, and the next transaction starts fresh.
- R9: No write pulse occurs during a read transaction, and the output-enable is never high during a write transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Select, active low |
| spi_sclk | input | 1 | Serial clock from host, idles low |
| spi_sdio_in | input | 1 | Data line as seen from the pad |
| spi_sdio_out | output | 1 | Data driven onto the line during reads |
| spi_sdio_oe | output | 1 | Pad output-enable, high drives the line |
| reg_addr | output | ADDR_W | Current register address |
| reg_wr_valid | output | 1 | One-cycle write pulse |
| reg_wr_data | output | DATA_W | Byte to write |
| reg_rd_data | input | DATA_W | Combinational read data for reg_addr |

## Verification
Two functions can fall into the same clock: completing a byte on its eighth rising edge, and aborting the transaction when select returns high. The bench provokes this by raising select and the serial clock on the same clock edge for the final bit of a write. It judges the result by requiring that no write pulse appears. Random transactions vary the direction, count code, start address (including addresses close to 0x1FFF, so the address wraps), the number of bytes sent beyond the allowed count and partial trailing bytes. Each result is compared against a bench model of the expected pulses and read bytes.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_WR   = 2'd1,
    PH_RD   = 2'd2,
    PH_DONE = 2'd3
  } phase_t;
endpackage

// File: rtl/spi3w_sync.sv
module spi3w_sync #(
  parameter int          STAGES    = 2,
  parameter int          WIDTH     = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi3w_front.sv
module spi3w_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csn_raw,
  input  logic sclk_raw,
  input  logic din_raw,
  output logic active,
  output logic rise,
  output logic fall,
  output logic din
);
  logic [2:0] synced;
  logic       sclk_d;

  spi3w_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({csn_raw, sclk_raw, din_raw}),
    .q    (synced)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= synced[1];

  assign active = ~synced[2];
  assign din    = synced[0];
  assign rise   = active &  synced[1] & ~sclk_d;
  assign fall   = active & ~synced[1] &  sclk_d;
endmodule

// File: rtl/spi3w_seq.sv
module spi3w_seq
  import spi3w_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              rise,
  input  logic              din,
  output phase_t            phase,
  output logic [ADDR_W-1:0] addr,
  output logic              load,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_data
);
  localparam int HDR_W = ADDR_W + 3;
  localparam int HCW   = $clog2(HDR_W);
  localparam int BCW   = $clog2(DATA_W);
  localparam logic [HCW-1:0] HDR_LAST  = HCW'(HDR_W - 1);
  localparam logic [BCW-1:0] BIT_LAST  = BCW'(DATA_W - 1);

  logic [HDR_W-1:0] rx_sr;
  logic [HDR_W-1:0] hdr_word;
  logic [DATA_W-1:0] byte_word;
  logic [HCW-1:0]   hdr_cnt;
  logic [BCW-1:0]   bit_cnt;
  logic [1:0]       byte_idx;
  logic [1:0]       cnt_code;
  logic             step;

  assign hdr_word  = {rx_sr[HDR_W-2:0], din};
  assign byte_word = {rx_sr[DATA_W-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_HDR;
      rx_sr    <= '0;
      hdr_cnt  <= '0;
      bit_cnt  <= '0;
      byte_idx <= '0;
      cnt_code <= '0;
      addr     <= '0;
      step     <= 1'b0;
      load     <= 1'b0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      step     <= 1'b0;
      load     <= 1'b0;
      if (step) begin
        addr <= addr + 1'b1;
        load <= (phase == PH_RD);
      end
      if (!active) begin
        phase    <= PH_HDR;
        hdr_cnt  <= '0;
        bit_cnt  <= '0;
        byte_idx <= '0;
        load     <= 1'b0;
      end else if (rise) begin
        rx_sr <= hdr_word;
        unique case (phase)
          PH_HDR: begin
            if (hdr_cnt == HDR_LAST) begin
              hdr_cnt  <= '0;
              phase    <= hdr_word[HDR_W-1] ? PH_RD : PH_WR;
              cnt_code <= hdr_word[HDR_W-2:HDR_W-3];
              addr     <= hdr_word[ADDR_W-1:0];
              load     <= hdr_word[HDR_W-1];
            end else begin
              hdr_cnt <= hdr_cnt + 1'b1;
            end
          end
          PH_WR, PH_RD: begin
            if (bit_cnt == BIT_LAST) begin
              bit_cnt <= '0;
              step    <= 1'b1;
              if (phase == PH_WR) begin
                wr_valid <= 1'b1;
                wr_data  <= byte_word;
              end
              if (cnt_code != 2'b11 && byte_idx == cnt_code) phase <= PH_DONE;
              else byte_idx <= byte_idx + 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi3w_tx.sv
module spi3w_tx
  import spi3w_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              fall,
  input  phase_t            phase,
  input  logic              load,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sdo,
  output logic              sdo_oe
);
  logic [DATA_W-1:0] tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr  <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else begin
      if (load) tx_sr <= rd_data;
      if (!active || phase != PH_RD) begin
        sdo_oe <= 1'b0;
      end else if (fall) begin
        sdo_oe <= 1'b1;
        sdo    <= tx_sr[DATA_W-1];
        tx_sr  <= {tx_sr[DATA_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi3w_regslave.sv
module spi3w_regslave
  import spi3w_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_csn,
  input  logic              spi_sclk,
  input  logic              spi_sdio_in,
  output logic              spi_sdio_out,
  output logic              spi_sdio_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr_valid,
  output logic [DATA_W-1:0] reg_wr_data,
  input  logic [DATA_W-1:0] reg_rd_data
);
  logic   link_active;
  logic   sclk_rise;
  logic   sclk_fall;
  logic   din_s;
  logic   rd_load;
  phase_t phase;

  spi3w_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .csn_raw (spi_csn),
    .sclk_raw(spi_sclk),
    .din_raw (spi_sdio_in),
    .active  (link_active),
    .rise    (sclk_rise),
    .fall    (sclk_fall),
    .din     (din_s)
  );

  spi3w_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (link_active),
    .rise    (sclk_rise),
    .din     (din_s),
    .phase   (phase),
    .addr    (reg_addr),
    .load    (rd_load),
    .wr_valid(reg_wr_valid),
    .wr_data (reg_wr_data)
  );

  spi3w_tx #(.DATA_W(DATA_W)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (link_active),
    .fall   (sclk_fall),
    .phase  (phase),
    .load   (rd_load),
    .rd_data(reg_rd_data),
    .sdo    (spi_sdio_out),
    .sdo_oe (spi_sdio_oe)
  );
endmodule

// File: rtl/spi3w_regslave_chk.sv
module spi3w_regslave_chk
  import spi3w_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              link_active,
  input logic              sclk_fall,
  input phase_t            phase,
  input logic              spi_sdio_out,
  input logic              spi_sdio_oe,
  input logic              reg_wr_valid,
  input logic [ADDR_W-1:0] reg_addr
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !link_active |=> (!spi_sdio_oe && !reg_wr_valid)); // R1

  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_active) |=> !spi_sdio_oe); // R8

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_valid |=> !reg_wr_valid); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_valid |=> reg_addr == $past(reg_addr) + 1'b1); // R7

  AST_NO_WR_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_valid |-> phase != PH_RD); // R9

  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sdio_oe |-> $past(phase) == PH_RD); // R9

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(spi_sdio_out)); // R6
endmodule

bind spi3w_regslave spi3w_regslave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .link_active (link_active),
  .sclk_fall   (sclk_fall),
  .phase       (phase),
  .spi_sdio_out(spi_sdio_out),
  .spi_sdio_oe (spi_sdio_oe),
  .reg_wr_valid(reg_wr_valid),
  .reg_addr    (reg_addr)
);

// File: tb/tb_spi3w_regslave.sv
`timescale 1ns/1ps
module tb_spi3w_regslave;
  localparam int H = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_csn = 1'b1;
  logic        spi_sclk = 1'b0;
  logic        spi_sdio_in = 1'b0;
  logic        spi_sdio_out;
  logic        spi_sdio_oe;
  logic [12:0] reg_addr;
  logic        reg_wr_valid;
  logic [7:0]  reg_wr_data;
  logic [7:0]  reg_rd_data;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  int          wr_cnt;
  logic [12:0] wr_a [0:31];
  logic [7:0]  wr_d [0:31];
  int          oe_write_hits;

  logic [7:0]  wdat  [0:15];
  logic [7:0]  rbyte [0:15];
  int          roe   [0:15];
  int          hdr_oe;

  always #4 clk = ~clk;

  spi3w_regslave dut (
    .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sclk(spi_sclk),
    .spi_sdio_in(spi_sdio_in), .spi_sdio_out(spi_sdio_out), .spi_sdio_oe(spi_sdio_oe),
    .reg_addr(reg_addr), .reg_wr_valid(reg_wr_valid), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data)
  );

  function automatic logic [7:0] bankf(input logic [12:0] a);
    return {a[4:0], a[12:10]} ^ a[9:2] ^ 8'h5A;
  endfunction

  assign reg_rd_data = bankf(reg_addr);

  always @(negedge clk) begin
    if (reg_wr_valid) begin
      if (wr_cnt < 32) begin
        wr_a[wr_cnt] = reg_addr;
        wr_d[wr_cnt] = reg_wr_data;
      end
      wr_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bitc(input bit v, input bit cs_with_rise, output bit so, output bit soe);
    @(negedge clk);
    spi_sclk    = 1'b0;
    spi_sdio_in = v;
    repeat (H) @(negedge clk);
    so  = spi_sdio_out;
    soe = spi_sdio_oe;
    spi_sclk = 1'b1;
    if (cs_with_rise) spi_csn = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic xfer(input bit rd, input logic [1:0] w, input logic [12:0] a,
                      input int nbytes, input int extra_bits, input bit cs_edge);
    logic [15:0] hdr;
    bit so, soe;
    int eff;
    hdr = {rd, w, a};
    wr_cnt = 0;
    hdr_oe = 0;
    oe_write_hits = 0;
    for (int j = 0; j < 16; j++) begin
      wdat[j] = 8'($urandom);
      rbyte[j] = 8'h00;
      roe[j] = 0;
    end
    @(negedge clk);
    spi_csn = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      bitc(hdr[15-i], 1'b0, so, soe);
      if (soe) hdr_oe++;
    end
    for (int j = 0; j < nbytes; j++) begin
      for (int b = 0; b < 8; b++) begin
        bitc(rd ? 1'b0 : wdat[j][7-b], cs_edge && (j == nbytes-1) && (b == 7), so, soe);
        rbyte[j] = {rbyte[j][6:0], so};
        if (soe) roe[j]++;
        if (!rd && soe) oe_write_hits++;
      end
    end
    for (int e = 0; e < extra_bits; e++) begin
      bitc(1'($urandom), 1'b0, so, soe);
      if (!rd && soe) oe_write_hits++;
    end
    @(negedge clk);
    spi_sclk = 1'b0;
    repeat (H) @(negedge clk);
    spi_csn = 1'b1;
    repeat (4) @(negedge clk);
    chk(spi_sdio_oe == 1'b0, "R8 oe released after select high", spi_sdio_oe, 0);
    repeat (3*H) @(negedge clk);

    eff = (w == 2'b11) ? nbytes : ((nbytes < int'(w) + 1) ? nbytes : int'(w) + 1);
    if (cs_edge) eff = eff - 1;
    chk(hdr_oe == 0, "R1 oe low during instruction", hdr_oe, 0);
    if (rd) begin
      chk(wr_cnt == 0, "R9 no write during read", wr_cnt, 0);
      for (int j = 0; j < nbytes; j++) begin
        if (j < eff) begin
          chk(rbyte[j] == bankf(13'(a + 13'(j))), "R6/R7 read byte",
              rbyte[j], bankf(13'(a + 13'(j))));
          chk(roe[j] == 8, "R6 oe during read byte", roe[j], 8);
        end else begin
          chk(roe[j] == 0, "R3 no drive past byte count", roe[j], 0);
        end
      end
    end else begin
      chk(oe_write_hits == 0, "R9 oe low during write", oe_write_hits, 0);
      chk(wr_cnt == eff, (w == 2'b11) ? "R4 stream write count" : "R3 write count",
          wr_cnt, eff);
      for (int j = 0; j < eff && j < 32; j++) begin
        chk(wr_a[j] == 13'(a + 13'(j)), "R7 write address", wr_a[j], 13'(a + 13'(j)));
        chk(wr_d[j] == wdat[j], "R5 write data", wr_d[j], wdat[j]);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk(spi_sdio_oe == 1'b0, "R1 reset oe", spi_sdio_oe, 0);
    chk(reg_wr_valid == 1'b0, "R1 reset write pulse", reg_wr_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(reg_addr == 13'h0, "R1 reset address", reg_addr, 0);

    xfer(1'b0, 2'b00, 13'h0123, 1, 0, 1'b0);   // R2 R5 single write
    xfer(1'b0, 2'b10, 13'h1ABC, 4, 0, 1'b0);   // R3 extra byte ignored
    xfer(1'b1, 2'b01, 13'h0F0F, 3, 0, 1'b0);   // R3 R6 read two, third undriven
    xfer(1'b1, 2'b11, 13'h1FFE, 4, 0, 1'b0);   // R4 R7 stream read wraps
    xfer(1'b0, 2'b11, 13'h1FFF, 3, 0, 1'b0);   // R4 R7 stream write wraps
    xfer(1'b0, 2'b11, 13'h0400, 2, 5, 1'b0);   // R8 partial byte dropped
    xfer(1'b1, 2'b00, 13'h0055, 1, 3, 1'b0);   // R8 abort on read
    xfer(1'b0, 2'b00, 13'h0777, 1, 0, 1'b1);   // R8 select rises with 8th edge
    xfer(1'b0, 2'b01, 13'h0002, 2, 0, 1'b0);   // R1 fresh after abort

    for (int t = 0; t < 30; t++) begin
      logic [12:0] a;
      a = 13'($urandom);
      if (t % 4 == 0) a = 13'h1FFF - 13'($urandom_range(0, 2));
      xfer(1'($urandom), 2'($urandom), a, $urandom_range(1, 5),
           $urandom_range(0, 7), 1'b0);
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule